// File: doc/BRIEF.md
# Target-to-Host Byte Packer

This block sits between an 8-bit byte source on the target side and a 16-bit host data path. In direct-memory mode it gathers two consecutive bytes into one word, the first byte into the upper half and the second into the lower half. Once the word is complete it raises a bus request and holds the word until the host grants. In programmed mode, and for every byte that arrives while the target is in its status phase, a byte lands alone in the lower half. A status flag then tells the polling host that a byte is waiting.

The byte input is a valid/ready stream. A byte moves only in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is low while a bus request is outstanding or a programmed byte is unread, so a new byte never overlaps a pending request. The source must hold `in_data` stable while `in_valid` is high and `in_ready` is low. The word side is a request/grant pair: `bus_req` acts as valid, `bus_gnt` acts as ready, and the word is taken in the cycle both are high. The remaining pins are plain level or pulse controls. A status byte also sets a sticky operation-complete flag, which the host clears with a one-cycle pulse.

Top module: `byte_packer`

## Requirements
- R1: After reset `bus_req`, `pio_full`, `op_done` and `xfer_active` are 0, `in_ready` is 1, and the next direct-memory byte goes to the upper half.
- R2: With `dma_en`=1 and `status_phase`=0, the first accepted byte of a word is written to `word_out[15:8]` and the second to `word_out[7:0]`.
- R3: `bus_req` rises in the cycle after the lower byte of a word is accepted, and at no other time.
- R4: While `bus_req` is 1, `in_ready` is 0.
- R5: `bus_req` stays 1 and `word_out` stays unchanged until a cycle with `bus_gnt`=1; `bus_req` is 0 in the following cycle.
- R6: With `dma_en`=0, an accepted byte is written to `word_out[7:0]`, `word_out[15:8]` keeps its value, and `pio_full` becomes 1.
- R7: With `status_phase`=1, bytes take the programmed path of R6 even when `dma_en`=1, and the upper/lower pointer does not move.
- R8: `pio_full` stays 1 until a cycle with `pio_rd`=1 and is 0 after it; while `pio_full` is 1, `in_ready` is 0.
- R9: A byte accepted with `status_phase`=1 sets `op_done`; `op_done` stays 1 until a `done_clr` pulse, and a set in the same cycle as `done_clr` wins.
- R10: `xfer_active` becomes 1 after an upper byte is accepted, stays 1 while the word is being filled and requested, and drops after the grant cycle, even when more bytes follow.
- R11: `bus_gnt` with no request pending, and `pio_rd` with `pio_full`=0, change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_en | input | 1 | 1 selects direct-memory packing, 0 selects programmed transfer |
| status_phase | input | 1 | Target is in status phase; forces the programmed path |
| in_valid | input | 1 | Byte offered by the target buffer |
| in_data | input | BYTE_W | Offered byte |
| in_ready | output | 1 | Byte accepted when high together with in_valid |
| pio_rd | input | 1 | Host read strobe for a programmed byte |
| pio_full | output | 1 | Programmed byte waiting for the host |
| done_clr | input | 1 | Host clear pulse for op_done |
| op_done | output | 1 | Sticky operation-complete flag |
| bus_gnt | input | 1 | Host grant; the word is taken when high with bus_req |
| bus_req | output | 1 | Word ready for the host |
| xfer_active | output | 1 | Word cycle in progress; falls at the end of the host cycle |
| word_out | output | 2*BYTE_W | Packed word, upper byte first |

## Verification
The bench goes after the grant that lands in the cycle right after the lower byte. A design with overlap would take a third byte there and corrupt the held word. It also covers status bytes that arrive between the two halves of a direct-memory word: a design that moved the pointer on them would put the next byte in the wrong half. Grant and read strobes are fired when nothing is pending, since a design that reacts to them would drop flags or requests it never raised. The bench also hits a `done_clr` pulse in the same cycle as a status byte, where a design with the wrong priority would lose the completion flag.

// File: rtl/byte_packer_pkg.sv
package byte_packer_pkg;
  typedef enum logic {SLOT_HI = 1'b0, SLOT_LO = 1'b1} slot_e;
  typedef enum logic [1:0] {
    ROUTE_NONE = 2'd0,
    ROUTE_PIO  = 2'd1,
    ROUTE_HI   = 2'd2,
    ROUTE_LO   = 2'd3
  } route_e;
endpackage

// File: rtl/bpk_route.sv
module bpk_route
  import byte_packer_pkg::*;
(
  input  logic   accept,
  input  logic   dma_en,
  input  logic   status_phase,
  input  slot_e  slot,
  output route_e route
);
  logic prog_path;
  assign prog_path = !dma_en || status_phase;

  always_comb begin
    route = ROUTE_NONE;
    if (accept) begin
      if (prog_path)             route = ROUTE_PIO;
      else if (slot == SLOT_HI)  route = ROUTE_HI;
      else                       route = ROUTE_LO;
    end
  end
endmodule

// File: rtl/bpk_word_reg.sv
module bpk_word_reg
  import byte_packer_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  route_e                route,
  input  logic [BYTE_W-1:0]     din,
  output logic [2*BYTE_W-1:0]   word
);
  localparam int LANES = 2;
  logic [LANES-1:0] lane_we;

  // lane 1 is the upper half, lane 0 the lower half
  assign lane_we[1] = (route == ROUTE_HI);
  assign lane_we[0] = (route == ROUTE_LO) || (route == ROUTE_PIO);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (!rst_n)          lane_q <= '0;
      else if (lane_we[g]) lane_q <= din;
    end
    assign word[g*BYTE_W +: BYTE_W] = lane_q;
  end
endmodule

// File: rtl/bpk_slot_ctrl.sv
module bpk_slot_ctrl
  import byte_packer_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  route_e route,
  input  logic   bus_gnt,
  output slot_e  slot,
  output logic   bus_req,
  output logic   xfer_active
);
  logic taken;
  assign taken = bus_req && bus_gnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot        <= SLOT_HI;
      bus_req     <= 1'b0;
      xfer_active <= 1'b0;
    end else begin
      if (taken) begin
        bus_req     <= 1'b0;
        xfer_active <= 1'b0;
      end
      case (route)
        ROUTE_HI: begin
          slot        <= SLOT_LO;
          xfer_active <= 1'b1;
        end
        ROUTE_LO: begin
          slot    <= SLOT_HI;
          bus_req <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bpk_flags.sv
module bpk_flags
  import byte_packer_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  route_e route,
  input  logic   status_phase,
  input  logic   pio_rd,
  input  logic   done_clr,
  output logic   pio_full,
  output logic   op_done
);
  logic prog_load;
  assign prog_load = (route == ROUTE_PIO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pio_full <= 1'b0;
      op_done  <= 1'b0;
    end else begin
      if (prog_load)   pio_full <= 1'b1;
      else if (pio_rd) pio_full <= 1'b0;
      if (prog_load && status_phase) op_done <= 1'b1;
      else if (done_clr)             op_done <= 1'b0;
    end
  end
endmodule

// File: rtl/byte_packer.sv
module byte_packer
  import byte_packer_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dma_en,
  input  logic                status_phase,
  input  logic                in_valid,
  input  logic [BYTE_W-1:0]   in_data,
  output logic                in_ready,
  input  logic                pio_rd,
  output logic                pio_full,
  input  logic                done_clr,
  output logic                op_done,
  input  logic                bus_gnt,
  output logic                bus_req,
  output logic                xfer_active,
  output logic [2*BYTE_W-1:0] word_out
);
  slot_e  slot;
  route_e route;
  logic   accept;

  // no new byte while a word request or a programmed byte is pending
  assign in_ready = !bus_req && !pio_full;
  assign accept   = in_valid && in_ready;

  bpk_route u_route (
    .accept(accept), .dma_en(dma_en), .status_phase(status_phase),
    .slot(slot), .route(route)
  );

  bpk_word_reg #(.BYTE_W(BYTE_W)) u_word (
    .clk(clk), .rst_n(rst_n), .route(route), .din(in_data), .word(word_out)
  );

  bpk_slot_ctrl u_slot (
    .clk(clk), .rst_n(rst_n), .route(route), .bus_gnt(bus_gnt),
    .slot(slot), .bus_req(bus_req), .xfer_active(xfer_active)
  );

  bpk_flags u_flags (
    .clk(clk), .rst_n(rst_n), .route(route), .status_phase(status_phase),
    .pio_rd(pio_rd), .done_clr(done_clr), .pio_full(pio_full), .op_done(op_done)
  );
endmodule

// File: rtl/byte_packer_checker.sv
module byte_packer_checker #(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic                pio_full,
  input logic                done_clr,
  input logic                op_done,
  input logic                bus_gnt,
  input logic                bus_req,
  input logic                xfer_active,
  input logic [2*BYTE_W-1:0] word_out
);
  assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !in_ready);

  assert_pio_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pio_full |-> !in_ready);

  assert_req_after_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(in_valid && in_ready));

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(word_out)));

  assert_req_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt) |=> !bus_req);

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && !done_clr) |=> op_done);

  assert_active_cover_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> xfer_active);
endmodule

bind byte_packer byte_packer_checker #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .pio_full(pio_full), .done_clr(done_clr), .op_done(op_done),
  .bus_gnt(bus_gnt), .bus_req(bus_req), .xfer_active(xfer_active),
  .word_out(word_out)
);

// File: tb/byte_packer_test.sv
`timescale 1ns/1ps
module byte_packer_test;
  localparam int BW = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dma_en = 1'b0, status_phase = 1'b0, in_valid = 1'b0;
  logic [BW-1:0] in_data = '0;
  logic pio_rd = 1'b0, done_clr = 1'b0, bus_gnt = 1'b0;
  logic in_ready, pio_full, op_done, bus_req, xfer_active;
  logic [2*BW-1:0] word_out;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  byte_packer #(.BYTE_W(BW)) uut (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .status_phase(status_phase),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .pio_rd(pio_rd), .pio_full(pio_full), .done_clr(done_clr), .op_done(op_done),
    .bus_gnt(bus_gnt), .bus_req(bus_req), .xfer_active(xfer_active),
    .word_out(word_out)
  );

  // behavioural reference
  int m_hi, m_lo, m_upper_next, m_req, m_pio, m_done, m_act;
  function automatic int m_ready();
    return (m_req == 0 && m_pio == 0) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hi = 0; m_lo = 0; m_upper_next = 1; m_req = 0; m_pio = 0; m_done = 0; m_act = 0;
    end else begin
      int take;
      take = (in_valid && m_ready() == 1) ? 1 : 0;
      if (bus_gnt && m_req == 1) begin m_req = 0; m_act = 0; end
      if (pio_rd) m_pio = 0;
      if (done_clr) m_done = 0;
      if (take == 1) begin
        if (!dma_en || status_phase) begin
          m_lo = int'(in_data); m_pio = 1;
          if (status_phase) m_done = 1;
        end else if (m_upper_next == 1) begin
          m_hi = int'(in_data); m_upper_next = 0; m_act = 1;
        end else begin
          m_lo = int'(in_data); m_upper_next = 1; m_req = 1;
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R4/R8 in_ready", int'(in_ready), m_ready());
    chk("R3/R5 bus_req", int'(bus_req), m_req);
    chk("R8 pio_full", int'(pio_full), m_pio);
    chk("R9 op_done", int'(op_done), m_done);
    chk("R10 xfer_active", int'(xfer_active), m_act);
    chk("R2/R6/R7 word_out", int'(word_out), (m_hi << 8) | m_lo);
  endtask

  task automatic drive(input int p_dma, input int p_stat, input int p_val,
                       input int p_gnt, input int p_rd, input int p_clr);
    dma_en       = ($urandom_range(99) < p_dma);
    status_phase = ($urandom_range(99) < p_stat);
    in_valid     = ($urandom_range(99) < p_val);
    in_data      = BW'($urandom_range(255));
    bus_gnt      = ($urandom_range(99) < p_gnt);
    pio_rd       = ($urandom_range(99) < p_rd);
    done_clr     = ($urandom_range(99) < p_clr);
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 bus_req", int'(bus_req), 0);
    chk("R1 pio_full", int'(pio_full), 0);
    chk("R1 op_done", int'(op_done), 0);
    chk("R1 xfer_active", int'(xfer_active), 0);
    chk("R1 in_ready", int'(in_ready), 1);

    // R11 spurious grant and read with nothing pending
    bus_gnt = 1; pio_rd = 1;
    step();
    chk("R11 word_out", int'(word_out), 0);
    bus_gnt = 0; pio_rd = 0;

    // R1/R2/R3 directed: first byte to upper half
    dma_en = 1; in_valid = 1; in_data = 8'hA5;
    step();
    chk("R2 upper", int'(word_out[15:8]), 8'hA5);
    chk("R10 active", int'(xfer_active), 1);
    chk("R3 no early req", int'(bus_req), 0);
    in_data = 8'h3C;
    step();
    chk("R2 lower", int'(word_out[7:0]), 8'h3C);
    chk("R3 req", int'(bus_req), 1);
    chk("R4 blocked", int'(in_ready), 0);
    in_data = 8'hFF; bus_gnt = 1;
    step();
    chk("R5 drop", int'(bus_req), 0);
    chk("R10 drop", int'(xfer_active), 0);
    chk("R5 word kept", int'(word_out), 16'hA53C);
    in_valid = 0; bus_gnt = 0;

    // R7/R9 status byte while a word is half filled, clear collision
    in_valid = 1; in_data = 8'h11;
    step();
    status_phase = 1; in_data = 8'h22; done_clr = 1;
    step();
    chk("R9 set wins", int'(op_done), 1);
    chk("R7 lower", int'(word_out[7:0]), 8'h22);
    status_phase = 0; done_clr = 0; in_valid = 0; pio_rd = 1;
    step();
    pio_rd = 0; in_valid = 1; in_data = 8'h33;
    step();
    chk("R7 pointer held", int'(bus_req), 1);
    in_valid = 0; bus_gnt = 1;
    step();
    bus_gnt = 0;

    // random phases: DMA heavy, PIO heavy, mixed with status
    for (int i = 0; i < 1500; i++) begin drive(95, 3, 70, 40, 30, 5); step(); end
    for (int i = 0; i < 1500; i++) begin drive(5, 3, 70, 40, 40, 5); step(); end
    for (int i = 0; i < 2000; i++) begin drive(60, 25, 60, 50, 50, 15); step(); end
    for (int i = 0; i < 1000; i++) begin drive(90, 10, 90, 90, 90, 30); step(); end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule